// File: doc/BRIEF.md
# Head-Step and Address-Mark Deadline Monitor

This block lives on the drive side of an emulated floppy interface. The host starts a head move by pulling the step register low. It then polls that register until it reads high again. The block shows the step as pending. It keeps a current-track number, moved one position in the direction the host selects. The step ends when the backing store signals that the new track can be served. While the step is pending, a millisecond timer runs. If the host's patience runs out before the track is ready, a step-deadline flag is raised.

A second timer covers reads. A read window opens when the read-active line rises. Every valid sector address mark presented to the host reopens the window, because the host takes whatever sector passes and keeps reading for the one it wants. If the window runs out with no valid mark, a mark-deadline flag is raised. A mark whose embedded track or sector is flagged as invalid does not satisfy the deadline. It raises a separate seek-fault flag instead. All three flags stay set until the clear input is pulsed. Both deadlines are parameters, because different hosts allow different times.

Top module: `step_deadline_monitor`

## Requirements
- R1: After reset, step_done is 1, track is 0, and step_miss, mark_miss and seek_fault are 0.
- R2: A cycle with step_req high makes step_done 0 from the next cycle on. step_done returns to 1 the cycle after track_ready is sampled high while the step is pending. It then stays 1 until the next step_req. track_ready has no effect while no step is pending.
- R3: Each step_req moves track by one. With step_in=1 it moves up and with step_in=0 it moves down. It stays at 0 going down and at TRACKS-1 going up.
- R4: While a step is pending, each tick without track_ready in the same cycle counts toward the step window. If the STEP_MS-th such tick comes with track_ready low, step_miss is 1 from the next cycle. A track_ready on that same tick ends the step with no miss.
- R5: A rising read_active opens the mark window. Every cycle with read_active, mark_sent and mark_ok all high restarts the window. If MARK_MS ticks go by in the window with no restart, mark_miss is set. The window then stays closed until it is reopened.
- R6: A cycle with read_active and mark_sent high and mark_ok low sets seek_fault. It does not restart the mark window.
- R7: While read_active is low, mark_sent has no effect: no flag is set and the window stays closed.
- R8: Both windows advance only on cycles with tick high. Any number of cycles without tick sets no deadline flag.
- R9: step_miss, mark_miss and seek_fault stay set until clear_flags is high. A cycle with clear_flags high zeroes all three, even if an event occurs in that same cycle.
- R10: A step_req while a step is pending restarts the step window from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable, once per millisecond |
| step_req | input | 1 | Host wrote 0 to the step register (one cycle) |
| step_in | input | 1 | Step direction: 1 up, 0 down |
| track_ready | input | 1 | Backing store can serve the new track |
| read_active | input | 1 | Host read in progress |
| mark_sent | input | 1 | A sector address mark is being presented |
| mark_ok | input | 1 | Embedded track and sector of that mark are valid |
| clear_flags | input | 1 | Zero all sticky flags |
| step_done | output | 1 | Step register value seen by the host |
| track | output | $clog2(TRACKS) | Current track number |
| step_miss | output | 1 | Sticky: step deadline missed |
| mark_miss | output | 1 | Sticky: address-mark deadline missed |
| seek_fault | output | 1 | Sticky: invalid mark presented during a read |

## Verification
The bench builds the block with STEP_MS=5, MARK_MS=7 and TRACKS=6. With these limits, each window runs out within a few dozen cycles of sparse ticks. Both saturation ends of the track counter can be reached in a handful of steps. The random phase can therefore hit expiry on the exact last tick, a ready or a mark landing on that tick, and a re-strobe mid-window, many times over. A cycle-level reference model in the bench predicts every output in every cycle.

// File: rtl/step_mon_pkg.sv
package step_mon_pkg;
  typedef enum logic {
    HEAD_SETTLED = 1'b0,
    HEAD_MOVING  = 1'b1
  } head_state_e;

  localparam int unsigned FLAG_STEP = 0;
  localparam int unsigned FLAG_MARK = 1;
  localparam int unsigned FLAG_SEEK = 2;
  localparam int unsigned FLAG_N    = 3;
endpackage

// File: rtl/sdm_window_timer.sv
module sdm_window_timer #(
  parameter int unsigned LIMIT = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
    end else if (start) begin
      elapsed <= '0;
    end else if (run && tick && elapsed != FULL) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expire = run && tick && !start && (elapsed == LAST);

  AST_TIMER_CAP: assert property (@(posedge clk) disable iff (rst)
    elapsed <= FULL); // R4
  AST_TIMER_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick && !start |=> $stable(elapsed)); // R8
endmodule

// File: rtl/sdm_track_counter.sv
module sdm_track_counter #(
  parameter int unsigned TRACKS = 80
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        strobe,
  input  logic                        dir_up,
  output logic [$clog2(TRACKS)-1:0]   track
);
  localparam int unsigned TW = $clog2(TRACKS);
  localparam logic [TW-1:0] TOP = TW'(TRACKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      track <= '0;
    end else if (strobe) begin
      if (dir_up) begin
        if (track != TOP) track <= track + 1'b1;
      end else begin
        if (track != '0) track <= track - 1'b1;
      end
    end
  end

  AST_TRACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    track <= TOP); // R3
  AST_TRACK_UP: assert property (@(posedge clk) disable iff (rst)
    strobe && dir_up && track != TOP |=> track == $past(track) + 1'b1); // R3
  AST_TRACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(track)); // R3
endmodule

// File: rtl/sdm_step_ctrl.sv
module sdm_step_ctrl
  import step_mon_pkg::*;
#(
  parameter int unsigned STEP_MS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic ready,
  input  logic tick,
  output logic moving,
  output logic miss_evt
);
  head_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HEAD_SETTLED;
    end else if (strobe) begin
      state <= HEAD_MOVING;
    end else if (state == HEAD_MOVING && ready) begin
      state <= HEAD_SETTLED;
    end
  end

  assign moving = (state == HEAD_MOVING);

  sdm_window_timer #(.LIMIT(STEP_MS)) step_timer_i (
    .clk    (clk),
    .rst    (rst),
    .start  (strobe),
    .run    (moving && !ready),
    .tick   (tick),
    .expire (miss_evt)
  );

  AST_STROBE_MOVES: assert property (@(posedge clk) disable iff (rst)
    strobe |=> moving); // R2
  AST_READY_SETTLES: assert property (@(posedge clk) disable iff (rst)
    moving && ready && !strobe |=> !moving); // R2
  AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !moving && !strobe |=> !moving); // R2
  AST_NO_MISS_SETTLED: assert property (@(posedge clk) disable iff (rst)
    !moving |-> !miss_evt); // R4
endmodule

// File: rtl/sdm_mark_watch.sv
module sdm_mark_watch #(
  parameter int unsigned MARK_MS = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic reading,
  input  logic mark,
  input  logic mark_good,
  input  logic tick,
  output logic miss_evt,
  output logic seek_evt
);
  logic reading_q;
  logic window_open;
  logic opened;
  logic restart;

  assign opened  = reading && !reading_q;
  assign restart = opened || (reading && mark && mark_good);

  always_ff @(posedge clk) begin
    if (rst) begin
      reading_q   <= 1'b0;
      window_open <= 1'b0;
    end else begin
      reading_q <= reading;
      if (!reading) begin
        window_open <= 1'b0;
      end else if (restart) begin
        window_open <= 1'b1;
      end else if (miss_evt) begin
        window_open <= 1'b0;
      end
    end
  end

  sdm_window_timer #(.LIMIT(MARK_MS)) mark_timer_i (
    .clk    (clk),
    .rst    (rst),
    .start  (restart),
    .run    (window_open && reading),
    .tick   (tick),
    .expire (miss_evt)
  );

  assign seek_evt = reading && mark && !mark_good;

  AST_NO_MISS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reading |-> !miss_evt && !seek_evt); // R7
  AST_MARK_REOPENS: assert property (@(posedge clk) disable iff (rst)
    reading && mark && mark_good |=> !miss_evt || !reading); // R5
endmodule

// File: rtl/step_deadline_monitor.sv
module step_deadline_monitor
  import step_mon_pkg::*;
#(
  parameter int unsigned STEP_MS = 12,
  parameter int unsigned MARK_MS = 23,
  parameter int unsigned TRACKS  = 80
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       step_req,
  input  logic                       step_in,
  input  logic                       track_ready,
  input  logic                       read_active,
  input  logic                       mark_sent,
  input  logic                       mark_ok,
  input  logic                       clear_flags,
  output logic                       step_done,
  output logic [$clog2(TRACKS)-1:0]  track,
  output logic                       step_miss,
  output logic                       mark_miss,
  output logic                       seek_fault
);
  logic              moving;
  logic [FLAG_N-1:0] evt;
  logic [FLAG_N-1:0] flag;

  sdm_step_ctrl #(.STEP_MS(STEP_MS)) step_ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (step_req),
    .ready    (track_ready),
    .tick     (tick),
    .moving   (moving),
    .miss_evt (evt[FLAG_STEP])
  );

  sdm_track_counter #(.TRACKS(TRACKS)) track_ctr_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (step_req),
    .dir_up (step_in),
    .track  (track)
  );

  sdm_mark_watch #(.MARK_MS(MARK_MS)) mark_watch_i (
    .clk       (clk),
    .rst       (rst),
    .reading   (read_active),
    .mark      (mark_sent),
    .mark_good (mark_ok),
    .tick      (tick),
    .miss_evt  (evt[FLAG_MARK]),
    .seek_evt  (evt[FLAG_SEEK])
  );

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clear_flags) begin
        flag[g] <= 1'b0;
      end else if (evt[g]) begin
        flag[g] <= 1'b1;
      end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      flag[g] && !clear_flags |=> flag[g]); // R9
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
      clear_flags |=> !flag[g]); // R9
  end

  assign step_done  = !moving;
  assign step_miss  = flag[FLAG_STEP];
  assign mark_miss  = flag[FLAG_MARK];
  assign seek_fault = flag[FLAG_SEEK];

  AST_MISS_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick && !clear_flags && !step_miss |=> !step_miss); // R8
endmodule

// File: tb/step_deadline_monitor_tb_top.sv
module step_deadline_monitor_tb_top;
  localparam int unsigned S_MS = 5;
  localparam int unsigned M_MS = 7;
  localparam int unsigned NTRK = 6;
  localparam int unsigned TW   = $clog2(NTRK);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, step_req = 0, step_in = 0, track_ready = 0;
  logic read_active = 0, mark_sent = 0, mark_ok = 0, clear_flags = 0;
  logic step_done, step_miss, mark_miss, seek_fault;
  logic [TW-1:0] track;

  always #5 clk = ~clk;

  step_deadline_monitor #(.STEP_MS(S_MS), .MARK_MS(M_MS), .TRACKS(NTRK)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .step_req(step_req), .step_in(step_in),
    .track_ready(track_ready), .read_active(read_active), .mark_sent(mark_sent),
    .mark_ok(mark_ok), .clear_flags(clear_flags), .step_done(step_done),
    .track(track), .step_miss(step_miss), .mark_miss(mark_miss), .seek_fault(seek_fault)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  bit m_moving, m_rd_q, m_open, m_smiss, m_mmiss, m_seek;
  int m_trk, m_scnt, m_mcnt;

  function automatic int sat_step(int t, bit up);
    if (up) return (t == NTRK - 1) ? t : t + 1;
    return (t == 0) ? 0 : t - 1;
  endfunction

  task automatic model_edge();
    bit se, me, ke, rise, good;
    se = 0; me = 0; ke = 0;
    if (rst) begin
      m_moving = 0; m_rd_q = 0; m_open = 0; m_trk = 0; m_scnt = 0; m_mcnt = 0;
      m_smiss = 0; m_mmiss = 0; m_seek = 0;
      return;
    end
    if (step_req) begin
      m_moving = 1; m_scnt = 0; m_trk = sat_step(m_trk, step_in);
    end else if (m_moving && track_ready) begin
      m_moving = 0;
    end else if (m_moving && tick) begin
      if (m_scnt == S_MS - 1) se = 1;
      if (m_scnt < S_MS) m_scnt++;
    end
    rise = read_active && !m_rd_q;
    good = read_active && mark_sent && mark_ok;
    ke = read_active && mark_sent && !mark_ok;
    if (!read_active) m_open = 0;
    else if (rise || good) begin m_open = 1; m_mcnt = 0; end
    else if (m_open && tick) begin
      if (m_mcnt == M_MS - 1) begin me = 1; m_open = 0; end
      if (m_mcnt < M_MS) m_mcnt++;
    end
    m_rd_q = read_active;
    if (clear_flags) begin m_smiss = 0; m_mmiss = 0; m_seek = 0; end
    else begin m_smiss |= se; m_mmiss |= me; m_seek |= ke; end
  endtask

  task automatic chk1(string req, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(string req);
    @(posedge clk);
    model_edge();
    #2;
    vectors++;
    chk1(req, "step_done", step_done, !m_moving);
    chk1(req, "track", track, m_trk);
    chk1(req, "step_miss", step_miss, m_smiss);
    chk1(req, "mark_miss", mark_miss, m_mmiss);
    chk1(req, "seek_fault", seek_fault, m_seek);
  endtask

  task automatic quiet();
    tick = 0; step_req = 0; track_ready = 0; mark_sent = 0; mark_ok = 0; clear_flags = 0;
  endtask

  task automatic ticks(string req, int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(req); tick = 0; cyc(req);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst = 1; cyc("R1"); cyc("R1");
    rst = 0; cyc("R1");
    chk1("R1", "reset step_done", step_done, 1);
    chk1("R1", "reset track", track, 0);

    // R2 / R3: three steps up with ready
    for (int i = 0; i < 3; i++) begin
      step_in = 1; step_req = 1; cyc("R2"); step_req = 0;
      cyc("R2"); cyc("R2");
      track_ready = 1; cyc("R2"); track_ready = 0; cyc("R2");
    end
    chk1("R3", "track after 3 up", track, 3);
    // R2: ready while settled has no effect
    track_ready = 1; cyc("R2"); cyc("R2"); track_ready = 0;
    // R3: saturate top then bottom
    for (int i = 0; i < 8; i++) begin step_in = 1; step_req = 1; cyc("R3"); end
    step_req = 0; cyc("R3");
    chk1("R3", "top saturation", track, NTRK - 1);
    for (int i = 0; i < 9; i++) begin step_in = 0; step_req = 1; cyc("R3"); end
    step_req = 0; cyc("R3");
    chk1("R3", "bottom saturation", track, 0);
    track_ready = 1; cyc("R3"); track_ready = 0;

    // R8: long pending step without ticks
    step_in = 1; step_req = 1; cyc("R8"); step_req = 0;
    for (int i = 0; i < 40; i++) cyc("R8");
    chk1("R8", "no miss without tick", step_miss, 0);
    // R4: ready on the final tick avoids the miss
    ticks("R4", S_MS - 1);
    tick = 1; track_ready = 1; cyc("R4"); quiet(); cyc("R4");
    chk1("R4", "ready on last tick", step_miss, 0);
    // R10: restrobe mid-window
    step_req = 1; cyc("R10"); step_req = 0;
    ticks("R10", S_MS - 1);
    step_req = 1; cyc("R10"); step_req = 0;
    ticks("R10", S_MS - 1);
    chk1("R10", "restart no miss", step_miss, 0);
    // R4: expiry
    ticks("R4", 1);
    chk1("R4", "step deadline", step_miss, 1);
    ticks("R9", 3);
    chk1("R9", "sticky", step_miss, 1);
    // R9: clear wins against a same-cycle event
    track_ready = 1; cyc("R9"); quiet();
    read_active = 1; mark_sent = 1; mark_ok = 0; clear_flags = 1; cyc("R9"); quiet();
    chk1("R9", "clear wins", seek_fault, 0);

    // R5: restart by valid mark, then expire
    read_active = 0; cyc("R5"); read_active = 1; cyc("R5");
    ticks("R5", M_MS - 1);
    mark_sent = 1; mark_ok = 1; cyc("R5"); quiet();
    ticks("R5", M_MS - 1);
    chk1("R5", "reopened window", mark_miss, 0);
    // R6: invalid mark does not reopen
    mark_sent = 1; mark_ok = 0; cyc("R6"); quiet();
    chk1("R6", "seek fault", seek_fault, 1);
    ticks("R5", 1);
    chk1("R5", "mark deadline", mark_miss, 1);
    clear_flags = 1; cyc("R9"); quiet();
    // R7: marks ignored while not reading
    read_active = 0; cyc("R7");
    for (int i = 0; i < 5; i++) begin mark_sent = 1; mark_ok = i[0]; cyc("R7"); end
    quiet(); ticks("R7", M_MS + 2);
    chk1("R7", "idle marks ignored", seek_fault + mark_miss, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      tick        = ($urandom % 3) == 0;
      step_req    = ($urandom % 20) == 0;
      step_in     = ($urandom % 2) == 0;
      track_ready = ($urandom % 12) == 0;
      if (($urandom % 40) == 0) read_active = !read_active;
      mark_sent   = ($urandom % 14) == 0;
      mark_ok     = ($urandom % 4) != 0;
      clear_flags = ($urandom % 60) == 0;
      rst         = ($urandom % 2000) == 0;
      cyc("R2");
    end
    rst = 0; quiet(); cyc("R1");
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule